// File: doc/BRIEF.md
# Cluster Power-Up and Boot Tracker

This block brings up one of two CPU clusters and keeps a use count for every core. When a boot request names a core whose count is zero and whose whole cluster is down (all of that cluster's counts are zero), the block runs the cluster bring-up. It first raises the coherency-inactive handshake for the cluster, then puts the cluster's reset and reset-disable lines into their power-up state, and then clears the cluster power gate. After a settle time measured in microsecond ticks it releases the shared cluster resets, and it drops the handshake as the final step. It then strobes a separate per-core sequencer and waits for that sequencer's done handshake.

If the cluster is already up, the core sequencer is started at once and the first-comer flag is cleared. If the requested core already has a nonzero count, no sequencing happens and only its count goes up. Requests are handled one at a time behind a ready output. The boot core's count starts at one. Its position is set by parameters.

Top module: `cluster_boot_tracker`

## Requirements
- R1: After reset the block has req_ready=1, core_start=0 and first_comer=0. coh_inact is all zero. Every active-low reset output is 1 and every rst_dis bit is 1. clu_gate is 0 for the boot cluster and 1 for every other cluster.
- R2: A request for a core in a cluster that is down runs the cluster sequence and shows first_comer=1 at the start strobe. coh_inact of that cluster is 1 before any of its reset lines goes low. It is still 1 when the shared cluster resets are released, and it is 0 by the time core_start pulses.
- R3: The cluster sequence drives low all CPC core_por_n lines, dbg_soc_rst_n, all CPC dbg_rst_n lines, h_rst_n and l2_rst_n of the target cluster. It also drives low all CPC trace_rst_n lines, but only when req_big=0. Outputs of the other cluster do not change.
- R4: Each cluster owns a CPC+1 bit slice of rst_dis. Bits CPC-1..0 are the L1 disables and bit CPC is the small-core L2 disable. For req_big=1 only bit 0 is cleared. For req_big=0 the whole slice is cleared.
- R5: The cluster gate is cleared while the cluster resets are held. dbg_soc_rst_n, h_rst_n and l2_rst_n are released after exactly SETTLE_US us_tick pulses, counted from the gate clear. core_por_n, dbg_rst_n and trace_rst_n stay low.
- R6: A request for a zero-count core in a cluster that has any nonzero count clears first_comer and pulses core_start without changing any cluster output. The boot core's count starts at 1, so its cluster counts as up from reset.
- R7: A request for a core with a nonzero count gives no core_start and changes no output. The count is still incremented and req_ready returns to 1.
- R8: core_start is a one-cycle pulse with start_cluster and start_core equal to the request. req_ready is 0 from the cycle after acceptance until core_done has been seen, or until the skip in R7 has completed.
- R9: Use counts saturate at 2^CNT_W-1 and never wrap back to zero.
- R10: req_valid raised while req_ready=0 is ignored and does not change any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Boot request valid, taken when req_ready=1 |
| req_cluster | input | CL_W | Cluster index of the request |
| req_core | input | CO_W | Core index within the cluster |
| req_big | input | 1 | 1 = big-core cluster, 0 = small-core cluster |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| core_done | input | 1 | Core sequencer finished |
| req_ready | output | 1 | Idle and able to take a request |
| core_start | output | 1 | One-cycle start strobe to the core sequencer |
| start_cluster | output | CL_W | Cluster of the started core |
| start_core | output | CO_W | Index of the started core |
| first_comer | output | 1 | 1 when the last started core brought its cluster up |
| coh_inact | output | NC | Coherency-inactive handshake per cluster |
| core_por_n | output | NC*CPC | Core power-on resets, active low |
| dbg_soc_rst_n | output | NC | Cluster debug SoC reset, active low |
| dbg_rst_n | output | NC*CPC | Per-core debug resets, active low |
| trace_rst_n | output | NC*CPC | Per-core trace resets, active low |
| h_rst_n | output | NC | Cluster H reset, active low |
| l2_rst_n | output | NC | Cluster L2 reset, active low |
| rst_dis | output | NC*(CPC+1) | L1/L2 reset-disable lines per cluster |
| clu_gate | output | NC | Cluster power gate, 1 = gated off |

## Verification
A wrong use count does not show at once. It shows on the next request to the same cluster, as a missing or extra core_start or as a wrong first_comer. The wrap case only shows after the count's full range of boots. A sequencer that skips or reorders a step shows within one cycle of that step: a reset line falls while coh_inact is low, or the handshake drops before the releases. A settle timer that is off by one shows as a tick count between gate clear and release that differs from SETTLE_US.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  // register write performed on the target cluster in the current step
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_INACT_ON,
    ACT_POR,
    ACT_CRST,
    ACT_DIS,
    ACT_GATE,
    ACT_REL,
    ACT_INACT_OFF
  } cbt_act_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INACT_ON,
    ST_POR,
    ST_CRST,
    ST_DIS,
    ST_GATE,
    ST_WAIT,
    ST_REL,
    ST_INACT_OFF,
    ST_START,
    ST_WDONE,
    ST_FIN
  } cbt_state_e;

endpackage

// File: rtl/cbt_use_count.sv
module cbt_use_count #(
  parameter int NC           = 2,
  parameter int CPC          = 4,
  parameter int CNT_W        = 4,
  parameter int BOOT_CLUSTER = 0,
  parameter int BOOT_CORE    = 0,
  parameter int CL_W         = 1,
  parameter int CO_W         = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CL_W-1:0] rd_cluster,
  input  logic [CO_W-1:0] rd_core,
  output logic            cur_nonzero,
  output logic            cluster_down,
  input  logic            inc_en,
  input  logic [CL_W-1:0] inc_cluster,
  input  logic [CO_W-1:0] inc_core
);
  localparam int N        = NC * CPC;
  localparam int IDX_W    = (N > 1) ? $clog2(N) : 1;
  localparam int BOOT_IDX = BOOT_CLUSTER * CPC + BOOT_CORE;

  logic [CNT_W-1:0] cnt_q [N];
  logic [IDX_W-1:0] inc_idx, rd_idx, rd_base;

  assign inc_idx = IDX_W'(inc_cluster) * IDX_W'(CPC) + IDX_W'(inc_core);
  assign rd_base = IDX_W'(rd_cluster) * IDX_W'(CPC);
  assign rd_idx  = rd_base + IDX_W'(rd_core);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++)
        cnt_q[i] <= (i == BOOT_IDX) ? CNT_W'(1) : '0;
    end else if (inc_en && (cnt_q[inc_idx] != {CNT_W{1'b1}})) begin
      cnt_q[inc_idx] <= cnt_q[inc_idx] + CNT_W'(1);
    end
  end

  assign cur_nonzero = (cnt_q[rd_idx] != '0);

  always_comb begin
    cluster_down = 1'b1;
    for (int k = 0; k < CPC; k++)
      if (cnt_q[rd_base + IDX_W'(k)] != '0) cluster_down = 1'b0;
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_chk
      // R9
      no_count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[g] != '0) |=> (cnt_q[g] != '0));
    end
  endgenerate

endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
  import cbt_pkg::*;
#(
  parameter int SETTLE_US = 20,
  parameter int CL_W      = 1,
  parameter int CO_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [CL_W-1:0] req_cluster,
  input  logic [CO_W-1:0] req_core,
  input  logic            req_big,
  input  logic            us_tick,
  input  logic            core_done,
  input  logic            cur_nonzero,
  input  logic            cluster_down,
  output logic            ready,
  output cbt_act_e        act,
  output logic [CL_W-1:0] tgt_cluster,
  output logic [CO_W-1:0] tgt_core,
  output logic            tgt_big,
  output logic            first_comer,
  output logic            core_start,
  output logic            inc_en
);
  localparam int TMR_W = $clog2(SETTLE_US + 1);

  cbt_state_e       state;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tgt_cluster <= '0;
      tgt_core    <= '0;
      tgt_big     <= 1'b0;
      tmr         <= '0;
      first_comer <= 1'b0;
      core_start  <= 1'b0;
    end else begin
      core_start <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          tgt_cluster <= req_cluster;
          tgt_core    <= req_core;
          tgt_big     <= req_big;
          if (cur_nonzero) begin
            state <= ST_FIN;
          end else if (cluster_down) begin
            first_comer <= 1'b1;
            state       <= ST_INACT_ON;
          end else begin
            first_comer <= 1'b0;
            state       <= ST_START;
          end
        end
        ST_INACT_ON:  state <= ST_POR;
        ST_POR:       state <= ST_CRST;
        ST_CRST:      state <= ST_DIS;
        ST_DIS:       state <= ST_GATE;
        ST_GATE: begin
          tmr   <= '0;
          state <= ST_WAIT;
        end
        ST_WAIT: if (us_tick) begin
          if (tmr == TMR_W'(SETTLE_US - 1)) state <= ST_REL;
          else tmr <= tmr + TMR_W'(1);
        end
        ST_REL:       state <= ST_INACT_OFF;
        ST_INACT_OFF: state <= ST_START;
        ST_START: begin
          core_start <= 1'b1;
          state      <= ST_WDONE;
        end
        ST_WDONE: if (core_done) state <= ST_FIN;
        ST_FIN:       state <= ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_INACT_ON:  act = ACT_INACT_ON;
      ST_POR:       act = ACT_POR;
      ST_CRST:      act = ACT_CRST;
      ST_DIS:       act = ACT_DIS;
      ST_GATE:      act = ACT_GATE;
      ST_REL:       act = ACT_REL;
      ST_INACT_OFF: act = ACT_INACT_OFF;
      default:      act = ACT_NONE;
    endcase
  end

  assign ready  = (state == ST_IDLE);
  assign inc_en = (state == ST_FIN);

  // R5
  settle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REL) |-> $past(us_tick));

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

endmodule

// File: rtl/cbt_cluster_regs.sv
module cbt_cluster_regs
  import cbt_pkg::*;
#(
  parameter int NC           = 2,
  parameter int CPC          = 4,
  parameter int BOOT_CLUSTER = 0,
  parameter int CL_W         = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cbt_act_e              act,
  input  logic [CL_W-1:0]       tgt_cluster,
  input  logic                  tgt_big,
  output logic [NC-1:0]         coh_inact,
  output logic [NC*CPC-1:0]     core_por_n,
  output logic [NC-1:0]         dbg_soc_rst_n,
  output logic [NC*CPC-1:0]     dbg_rst_n,
  output logic [NC*CPC-1:0]     trace_rst_n,
  output logic [NC-1:0]         h_rst_n,
  output logic [NC-1:0]         l2_rst_n,
  output logic [NC*(CPC+1)-1:0] rst_dis,
  output logic [NC-1:0]         clu_gate
);
  localparam int DIS_W = CPC + 1;

  generate
    for (genvar c = 0; c < NC; c++) begin : g_clu
      logic             inact_q, dsoc_q, h_q, l2_q, gate_q;
      logic [CPC-1:0]   por_q, dbg_q, trc_q;
      logic [DIS_W-1:0] dis_q;
      logic             hit;

      assign hit = (tgt_cluster == CL_W'(c));

      always_ff @(posedge clk) begin
        if (rst) begin
          inact_q <= 1'b0;
          por_q   <= '1;
          dsoc_q  <= 1'b1;
          dbg_q   <= '1;
          trc_q   <= '1;
          h_q     <= 1'b1;
          l2_q    <= 1'b1;
          dis_q   <= '1;
          gate_q  <= (c != BOOT_CLUSTER);
        end else if (hit) begin
          case (act)
            ACT_INACT_ON:  inact_q <= 1'b1;
            ACT_POR:       por_q   <= '0;
            ACT_CRST: begin
              dsoc_q <= 1'b0;
              dbg_q  <= '0;
              h_q    <= 1'b0;
              l2_q   <= 1'b0;
              if (!tgt_big) trc_q <= '0;
            end
            ACT_DIS: begin
              if (tgt_big) dis_q[0] <= 1'b0;
              else         dis_q    <= '0;
            end
            ACT_GATE:      gate_q <= 1'b0;
            ACT_REL: begin
              dsoc_q <= 1'b1;
              h_q    <= 1'b1;
              l2_q   <= 1'b1;
            end
            ACT_INACT_OFF: inact_q <= 1'b0;
            default: ;
          endcase
        end
      end

      assign coh_inact[c]                 = inact_q;
      assign core_por_n[c*CPC +: CPC]     = por_q;
      assign dbg_soc_rst_n[c]             = dsoc_q;
      assign dbg_rst_n[c*CPC +: CPC]      = dbg_q;
      assign trace_rst_n[c*CPC +: CPC]    = trc_q;
      assign h_rst_n[c]                   = h_q;
      assign l2_rst_n[c]                  = l2_q;
      assign rst_dis[c*DIS_W +: DIS_W]    = dis_q;
      assign clu_gate[c]                  = gate_q;

      // R2
      reset_under_inact_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(l2_q) |-> inact_q);
      // R2
      release_under_inact_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(l2_q) |-> inact_q);
      // R2
      inact_drop_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(inact_q) |-> (l2_q && h_q && dsoc_q));
      // R5
      gate_under_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_q) |-> (!l2_q && (por_q == '0)));
    end
  endgenerate

endmodule

// File: rtl/cluster_boot_tracker.sv
module cluster_boot_tracker
  import cbt_pkg::*;
#(
  parameter int NC           = 2,
  parameter int CPC          = 4,
  parameter int CNT_W        = 4,
  parameter int SETTLE_US    = 20,
  parameter int BOOT_CLUSTER = 0,
  parameter int BOOT_CORE    = 0,
  parameter int CL_W         = (NC > 1) ? $clog2(NC) : 1,
  parameter int CO_W         = (CPC > 1) ? $clog2(CPC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [CL_W-1:0]       req_cluster,
  input  logic [CO_W-1:0]       req_core,
  input  logic                  req_big,
  input  logic                  us_tick,
  input  logic                  core_done,
  output logic                  req_ready,
  output logic                  core_start,
  output logic [CL_W-1:0]       start_cluster,
  output logic [CO_W-1:0]       start_core,
  output logic                  first_comer,
  output logic [NC-1:0]         coh_inact,
  output logic [NC*CPC-1:0]     core_por_n,
  output logic [NC-1:0]         dbg_soc_rst_n,
  output logic [NC*CPC-1:0]     dbg_rst_n,
  output logic [NC*CPC-1:0]     trace_rst_n,
  output logic [NC-1:0]         h_rst_n,
  output logic [NC-1:0]         l2_rst_n,
  output logic [NC*(CPC+1)-1:0] rst_dis,
  output logic [NC-1:0]         clu_gate
);
  logic     cur_nonzero, cluster_down, inc_en, tgt_big;
  cbt_act_e act;

  cbt_use_count #(
    .NC(NC), .CPC(CPC), .CNT_W(CNT_W), .BOOT_CLUSTER(BOOT_CLUSTER),
    .BOOT_CORE(BOOT_CORE), .CL_W(CL_W), .CO_W(CO_W)
  ) u_cnt (
    .clk(clk), .rst(rst),
    .rd_cluster(req_cluster), .rd_core(req_core),
    .cur_nonzero(cur_nonzero), .cluster_down(cluster_down),
    .inc_en(inc_en), .inc_cluster(start_cluster), .inc_core(start_core)
  );

  cbt_seq #(
    .SETTLE_US(SETTLE_US), .CL_W(CL_W), .CO_W(CO_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_cluster(req_cluster), .req_core(req_core),
    .req_big(req_big), .us_tick(us_tick), .core_done(core_done),
    .cur_nonzero(cur_nonzero), .cluster_down(cluster_down),
    .ready(req_ready), .act(act), .tgt_cluster(start_cluster),
    .tgt_core(start_core), .tgt_big(tgt_big), .first_comer(first_comer),
    .core_start(core_start), .inc_en(inc_en)
  );

  cbt_cluster_regs #(
    .NC(NC), .CPC(CPC), .BOOT_CLUSTER(BOOT_CLUSTER), .CL_W(CL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .act(act), .tgt_cluster(start_cluster),
    .tgt_big(tgt_big), .coh_inact(coh_inact), .core_por_n(core_por_n),
    .dbg_soc_rst_n(dbg_soc_rst_n), .dbg_rst_n(dbg_rst_n),
    .trace_rst_n(trace_rst_n), .h_rst_n(h_rst_n), .l2_rst_n(l2_rst_n),
    .rst_dis(rst_dis), .clu_gate(clu_gate)
  );

  // R2
  start_after_inact_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |-> !coh_inact[start_cluster]);

endmodule

// File: tb/sim_cluster_boot_tracker.sv
`timescale 1ns/1ps
module sim_cluster_boot_tracker;
  localparam int NC = 2, CPC = 4, SETTLE = 20, DW = CPC + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_big = 1'b0, us_tick = 1'b0, core_done = 1'b0;
  logic [0:0] req_cluster = '0;
  logic [1:0] req_core = '0;
  logic req_ready, core_start, first_comer;
  logic [0:0] start_cluster;
  logic [1:0] start_core;
  logic [NC-1:0] coh_inact, dbg_soc_rst_n, h_rst_n, l2_rst_n, clu_gate;
  logic [NC*CPC-1:0] core_por_n, dbg_rst_n, trace_rst_n;
  logic [NC*DW-1:0] rst_dis;

  always #4 clk = ~clk;

  cluster_boot_tracker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cluster(req_cluster),
    .req_core(req_core), .req_big(req_big), .us_tick(us_tick),
    .core_done(core_done), .req_ready(req_ready), .core_start(core_start),
    .start_cluster(start_cluster), .start_core(start_core),
    .first_comer(first_comer), .coh_inact(coh_inact), .core_por_n(core_por_n),
    .dbg_soc_rst_n(dbg_soc_rst_n), .dbg_rst_n(dbg_rst_n),
    .trace_rst_n(trace_rst_n), .h_rst_n(h_rst_n), .l2_rst_n(l2_rst_n),
    .rst_dis(rst_dis), .clu_gate(clu_gate)
  );

  int checks = 0, fails = 0, cyc = 0;

  // results of the last boot
  int   n_start, n_tick, s_cl, s_co;
  logic s_first, s_inact, saw_low, saw_rel, inact_low, inact_rel, ready_low_ok, completed;

  typedef struct packed {
    logic [3:0] cl;
    logic [3:0] co;
    logic       big;
    logic       exp_start;
    logic       exp_first;
    logic       exp_seq;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{4'd1, 4'd2, 1'b1, 1'b1, 1'b1, 1'b1},  // cluster 1 down: big sequence
    '{4'd1, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0},  // cluster 1 up
    '{4'd1, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0},  // repeat boot: skip
    '{4'd0, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0},  // boot cluster up via boot core
    '{4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0}   // boot core itself: skip
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] snap();
    return {20'b0, coh_inact, core_por_n, dbg_soc_rst_n, dbg_rst_n, trace_rst_n,
            h_rst_n, l2_rst_n, rst_dis, clu_gate};
  endfunction

  task automatic apply_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    chk(core_start === 1'b0 && first_comer === 1'b0, "R1 start/first", {core_start, first_comer}, 0);
    chk(coh_inact === '0, "R1 coh_inact", coh_inact, 0);
    chk(clu_gate === 2'b10, "R1 gate", clu_gate, 2'b10);
    chk({core_por_n, dbg_rst_n, trace_rst_n, dbg_soc_rst_n, h_rst_n, l2_rst_n} === '1,
        "R1 resets released", {core_por_n, dbg_rst_n, trace_rst_n}, 64'hffffff);
    chk(rst_dis === '1, "R1 rst_dis", rst_dis, 10'h3ff);
  endtask

  task automatic do_boot(input int cl, input int co, input bit big, input bit spam, input int spam_co);
    int  cd;
    bit  any_low;
    n_start = 0; n_tick = 0; s_cl = -1; s_co = -1; s_first = 1'bx; s_inact = 1'bx;
    saw_low = 0; saw_rel = 0; inact_low = 0; inact_rel = 0; completed = 0; cd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cluster = 1'(cl); req_core = 2'(co); req_big = big;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      if (n == 0) ready_low_ok = (req_ready === 1'b0);
      else if (req_ready) begin
        completed = 1;
        break;
      end
      if (core_start) begin
        n_start++; s_cl = int'(start_cluster); s_co = int'(start_core);
        s_first = first_comer; s_inact = coh_inact[cl]; cd = 3;
      end
      any_low = (core_por_n[cl*CPC +: CPC] != '1) || !l2_rst_n[cl];
      if (any_low && !saw_low) begin saw_low = 1; inact_low = coh_inact[cl]; end
      if (saw_low && l2_rst_n[cl] && !saw_rel) begin saw_rel = 1; inact_rel = coh_inact[cl]; end
      us_tick = (n % 4 == 3);
      if (us_tick && !clu_gate[cl] && !l2_rst_n[cl]) n_tick++;
      req_valid = spam && (cd > 1);
      if (spam) req_core = 2'(spam_co);
      core_done = (cd == 1);
      if (cd > 0) cd--;
      @(negedge clk);
    end
    us_tick = 1'b0; core_done = 1'b0; req_valid = 1'b0;
    chk(completed == 1, "R8 boot completed", completed, 1);
    chk(ready_low_ok == 1, "R8 ready low while busy", ready_low_ok, 1);
  endtask

  task automatic seq_checks(input int cl, input bit big);
    chk(s_first === 1'b1, "R2 first_comer", s_first, 1);
    chk(inact_low === 1'b1, "R2 inact before resets", inact_low, 1);
    chk(saw_rel && inact_rel === 1'b1, "R2 inact held at release", inact_rel, 1);
    chk(s_inact === 1'b0 && coh_inact[cl] === 1'b0, "R2 inact cleared before start", s_inact, 0);
    chk(core_por_n[cl*CPC +: CPC] === '0, "R3 por low", core_por_n[cl*CPC +: CPC], 0);
    chk(dbg_rst_n[cl*CPC +: CPC] === '0, "R3 dbg low", dbg_rst_n[cl*CPC +: CPC], 0);
    chk(trace_rst_n[cl*CPC +: CPC] === (big ? 4'hf : 4'h0), "R3 trace by type",
        trace_rst_n[cl*CPC +: CPC], big ? 4'hf : 4'h0);
    chk(rst_dis[cl*DW +: DW] === (big ? 5'b11110 : 5'b00000), "R4 disable slice",
        rst_dis[cl*DW +: DW], big ? 5'b11110 : 5'b00000);
    chk(n_tick == SETTLE, "R5 settle ticks", n_tick, SETTLE);
    chk(clu_gate[cl] === 1'b0, "R5 gate cleared", clu_gate[cl], 0);
    chk({dbg_soc_rst_n[cl], h_rst_n[cl], l2_rst_n[cl]} === 3'b111, "R5 shared resets released",
        {dbg_soc_rst_n[cl], h_rst_n[cl], l2_rst_n[cl]}, 3'b111);
  endtask

  initial begin
    logic [63:0] pre;
    logic [15:0] pre0;
    apply_reset();
    check_reset_state();

    for (int i = 0; i < 5; i++) begin
      pre = snap();
      do_boot(int'(TBL[i].cl), int'(TBL[i].co), TBL[i].big, 1'b0, 0);
      chk(n_start == int'(TBL[i].exp_start), TBL[i].exp_start ? "R8 one start" : "R7 no start",
          n_start, TBL[i].exp_start);
      if (TBL[i].exp_start) begin
        chk(s_cl == int'(TBL[i].cl) && s_co == int'(TBL[i].co), "R8 start index",
            {s_cl[7:0], s_co[7:0]}, {TBL[i].cl, TBL[i].co});
        chk(s_first === TBL[i].exp_first, "R6 first_comer", s_first, TBL[i].exp_first);
      end
      if (TBL[i].exp_seq) seq_checks(int'(TBL[i].cl), TBL[i].big);
      else chk(snap() === pre, TBL[i].exp_start ? "R6 outputs unchanged" : "R7 outputs unchanged",
               snap(), pre);
    end

    // small-core cluster sequence on a fresh cluster 1
    apply_reset();
    check_reset_state();
    pre0 = {core_por_n[3:0], dbg_rst_n[3:0], trace_rst_n[3:0], l2_rst_n[0], clu_gate[0], coh_inact[0], h_rst_n[0]};
    do_boot(1, 0, 1'b0, 1'b0, 0);
    chk(n_start == 1, "R8 one start", n_start, 1);
    seq_checks(1, 1'b0);
    chk({core_por_n[3:0], dbg_rst_n[3:0], trace_rst_n[3:0], l2_rst_n[0], clu_gate[0], coh_inact[0], h_rst_n[0]} === pre0,
        "R3 other cluster untouched",
        {core_por_n[3:0], dbg_rst_n[3:0], trace_rst_n[3:0], l2_rst_n[0], clu_gate[0], coh_inact[0], h_rst_n[0]}, pre0);
    chk(rst_dis[4:0] === 5'b11111, "R4 other slice untouched", rst_dis[4:0], 5'b11111);

    // R9: boot core count 1 plus 15 repeats would wrap a 4-bit count
    for (int k = 0; k < 15; k++) begin
      do_boot(0, 0, 1'b0, 1'b0, 0);
      chk(n_start == 0, "R7 repeat boot skipped", n_start, 0);
    end
    pre = snap();
    do_boot(0, 3, 1'b0, 1'b0, 0);
    chk(n_start == 1 && s_first === 1'b0, "R9 count saturated, cluster stays up",
        {n_start[7:0], 7'b0, s_first}, 16'h0100);
    chk(snap() === pre, "R9 no cluster sequence", snap(), pre);

    // R10: request held during busy is ignored
    do_boot(0, 2, 1'b0, 1'b1, 1);
    chk(n_start == 1 && s_co == 2, "R10 single start while busy", {n_start[7:0], s_co[7:0]}, 16'h0102);
    do_boot(0, 1, 1'b0, 1'b0, 0);
    chk(n_start == 1 && s_co == 1, "R10 ignored request not counted", {n_start[7:0], s_co[7:0]}, 16'h0101);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule